// File: doc/BRIEF.md
# Seven-Channel Serial ADC Scan Sequencer

This block is an SPI master that reads one external serial ADC across a fixed set of input channels. One start pulse runs a full scan. For each channel the block sends a command byte and then clocks a full-duplex frame of four bytes. From the bits that come back it rebuilds a 16-bit sample and writes it into that channel's result register. Chip select stays low for the entire scan. It goes high only once the last channel's sample has been written, and in that same cycle the block raises a data-available flag.

The result registers can be read at any time through a combinational port addressed by channel index. A register keeps its old value until the next scan writes that channel again. The available flag stays set until an explicit clear or a new accepted start. The serial clock runs at one sixteenth of the system clock and stops low whenever no scan is running.

Top module: `adc_scan_seq`

## Requirements
- R1: The first byte of each channel frame on MOSI is the command byte. Its bit 7 is 1, bits 6:4 hold the channel index, bit 3 is 0, bit 2 is 1 (single-ended) and bits 1:0 are 11, so for channel c the byte is 0x87 | (c << 4). The three bytes that follow are all zero.
- R2: Each channel frame is exactly 32 SCLK cycles, sent most significant bit first in SPI mode 0. MOSI changes only on falling SCLK edges and MISO is sampled on rising edges.
- R3: Let r[31:0] be the 32 bits received in a frame, with the first bit received in bit 31. The stored sample is r[22:7]: byte 1 and byte 2 moved up one place, with the top bit of byte 3 in bit 0.
- R4: A scan converts channels 0 to 6 in ascending order. Chip select falls at the clock edge that accepts the start and rises at the edge that stores the channel 6 sample, never between channels.
- R5: SCLK has a period of 16 system clocks. Its first rising edge comes 8 clocks after chip select falls, and it idles low whenever chip select is high.
- R6: busy_o is high from the accepting edge until the completing edge, and avail_o goes high at the completing edge. avail_o is cleared by clr_avail_i while idle or by an accepted start.
- R7: A start pulse that arrives while a scan is running is ignored.
- R8: A result register holds its value until its own channel is converted again. A read index of 7 returns 0.
- R9: While rst_ni is low, chip select is high, SCLK is low, busy and available are low, and every result register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| clr_avail_i | input | 1 | Clear the available flag |
| rd_idx_i | input | 3 | Result register index |
| rd_data_o | output | 16 | Sample of the indexed channel |
| busy_o | output | 1 | Scan in progress |
| avail_o | output | 1 | Fresh scan results available |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to the ADC |
| miso_i | input | 1 | SPI data from the ADC |
| cs_no | output | 1 | Active-low ADC chip select |

## Verification
A corrupted divider count or frame bit counter shifts the SCLK phase or the chip-select release. That error shows within one half period, so the clock-by-clock comparison of cs_no, sclk_o and busy_o catches it within eight cycles. A wrong channel counter or command builder puts the wrong field into the next command byte, and the ADC model catches it at the end of that frame, 512 cycles after its start at most. A wrong sample alignment or a misdirected register write shows on rd_data_o in the cycle after the store, because the index sweeps across all channels while scans are running.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned CMD_BITS   = 8;

  // start bit, channel, fixed 0, single-ended, power bits
  function automatic logic [CMD_BITS-1:0] build_cmd(input logic [2:0] ch);
    return {1'b1, ch, 1'b0, 1'b1, 2'b11};
  endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap = en_i && (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = wrap & ~sclk_q;
  assign fall_o = wrap & sclk_q;

  p_toggle_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && sclk_q != $past(sclk_q)) |=> $stable(sclk_q));
endmodule

// File: rtl/adc_spi_shift.sv
`timescale 1ns/1ps
module adc_spi_shift
  import adc_scan_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned SAMPLE_LSB = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CMD_BITS-1:0] cmd_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                miso_i,
  output logic                mosi_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                done_o
);
  localparam int unsigned RX_W  = SAMPLE_W + SAMPLE_LSB;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] tx_q;
  logic [RX_W-1:0]       rx_q;
  logic [BIT_W-1:0]      bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= {cmd_i, {(FRAME_BITS-CMD_BITS){1'b0}}};
      bit_q <= '0;
    end else if (fall_i) begin
      tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
      bit_q <= bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (rise_i) rx_q <= {rx_q[RX_W-2:0], miso_i};
  end

  assign mosi_o   = tx_q[FRAME_BITS-1];
  assign sample_o = rx_q[RX_W-1 -: SAMPLE_W];
  assign done_o   = fall_i && (bit_q == BIT_W'(FRAME_BITS - 1));

  p_rx_only_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(rx_q));
endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank #(
  parameter int unsigned NUM_CH   = 7,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [SAMPLE_W-1:0] rd_data_o
);
  logic [SAMPLE_W-1:0] bank_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bank_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   bank_q[g] <= wr_data_i;
    end

    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == IDX_W'(g)) |=> $stable(bank_q[g]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = bank_q[i];
  end
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH     = 7,
  parameter int unsigned CLK_DIV    = 16,
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned SAMPLE_LSB = 7,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                clr_avail_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                busy_o,
  output logic                avail_o,
  output logic                sclk_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                cs_no
);
  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

  logic                busy_q, avail_q;
  logic [IDX_W-1:0]    ch_q, next_ch;
  logic                start_acc, frame_done, last_ch, scan_end, load;
  logic                rise, fall;
  logic [SAMPLE_W-1:0] sample;

  assign start_acc = start_i & ~busy_q;
  assign last_ch   = (ch_q == LAST_CH);
  assign scan_end  = frame_done & last_ch;
  assign load      = start_acc | (frame_done & ~last_ch);
  assign next_ch   = start_acc ? '0 : IDX_W'(ch_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      avail_q <= 1'b0;
      ch_q    <= '0;
    end else if (start_acc) begin
      busy_q  <= 1'b1;
      avail_q <= 1'b0;
      ch_q    <= '0;
    end else if (frame_done) begin
      if (last_ch) begin
        busy_q  <= 1'b0;
        avail_q <= 1'b1;
        ch_q    <= '0;
      end else begin
        ch_q    <= next_ch;
      end
    end else if (clr_avail_i) begin
      avail_q <= 1'b0;
    end
  end

  adc_sclk_gen #(.DIV(CLK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_spi_shift #(.SAMPLE_W(SAMPLE_W), .SAMPLE_LSB(SAMPLE_LSB)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .cmd_i    (build_cmd(3'(next_ch))),
    .rise_i   (rise),
    .fall_i   (fall),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .sample_o (sample),
    .done_o   (frame_done)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (frame_done),
    .wr_idx_i  (ch_q),
    .wr_data_i (sample),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o  = busy_q;
  assign avail_o = avail_q;
  assign cs_no   = ~busy_q;

  p_cs_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> avail_o);
  p_ch_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !last_ch) |=> (ch_q == $past(ch_q) + 1'b1) && busy_o);
  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_mosi_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_complete_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_end |=> avail_o && !busy_o);
  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !scan_end) |=> busy_o && !cs_no);
endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NCH = 7, DIV = 16, HALF = 8, FB = 32;
  localparam int FRAME_CLK = FB * DIV;
  localparam int SCAN_LEN  = NCH * FRAME_CLK;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, clr_i = 1'b0, miso = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic busy, avail, sclk, mosi, cs_n;

  int vectors = 0, miscompares = 0;
  bit run_model = 1'b0;

  adc_scan_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clr_avail_i(clr_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .busy_o(busy), .avail_o(avail),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] adc_word(input int s, input int c);
    logic [31:0] x;
    x = 32'h1234_5678 + 32'(s) * 32'h9E37_79B9 + 32'(c) * 32'h7F4A_7C15;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model, stepped once per clock
  bit          m_busy = 1'b0, m_avail = 1'b0;
  int          k = 0, m_scan = 0;
  logic [15:0] m_res [8];
  logic [31:0] m_w;
  initial for (int i = 0; i < 8; i++) m_res[i] = '0;

  always @(negedge clk) if (run_model) begin
    if (m_busy) begin
      k++;
      if (k % FRAME_CLK == 0) begin
        m_w = adc_word(m_scan, k / FRAME_CLK - 1);
        m_res[k / FRAME_CLK - 1] = m_w[22:7];
      end
      if (k == SCAN_LEN) begin
        m_busy = 1'b0; m_avail = 1'b1; m_scan++;
      end
    end else if (start_i) begin
      m_busy = 1'b1; k = 0; m_avail = 1'b0;
    end else if (clr_i) begin
      m_avail = 1'b0;
    end
    chk("R4", "cs_n", 32'(cs_n), 32'(!m_busy));
    chk("R5", "sclk", 32'(sclk), m_busy ? 32'((k / HALF) % 2) : 32'd0);
    chk("R6", "busy", 32'(busy), 32'(m_busy));
    chk("R6", "avail", 32'(avail), 32'(m_avail));
    if (m_busy) chk("R8", "rd_data during scan", 32'(rd_data), 32'(m_res[rd_idx]));
    else        chk("R3", "rd_data idle", 32'(rd_data), 32'(m_res[rd_idx]));
  end

  // ADC slave model
  int          s_bit = 0, s_ch = 0, s_scan = 0;
  logic [31:0] s_mosi = '0, s_w;

  always @(negedge cs_n) if (run_model) begin
    s_bit = 0; s_ch = 0; s_mosi = '0;
    s_w = adc_word(s_scan, 0);
    miso = s_w[31];
  end

  always @(posedge sclk) s_mosi = {s_mosi[30:0], mosi};

  always @(negedge sclk) if (run_model) begin
    s_bit++;
    if (s_bit == FB) begin
      chk("R1", "command frame", s_mosi, {8'h87 | 8'(s_ch << 4), 24'h0});
      s_bit = 0; s_ch++;
      if (s_ch == NCH) s_scan++;
    end
    if (s_ch < NCH) begin
      s_w = adc_word(s_scan, s_ch);
      miso = s_w[31 - s_bit];
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1 clr_i = 1'b1;
    @(negedge clk); #1 clr_i = 1'b0;
  endtask

  task automatic sweep(input int cycles_per_idx);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 rd_idx = 3'(i);
      repeat (cycles_per_idx) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL R6 watchdog: got busy %0b expected scan completion", busy);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "cs_n", 32'(cs_n), 32'd1);
    chk("R9", "sclk", 32'(sclk), 32'd0);
    chk("R9", "busy", 32'(busy), 32'd0);
    chk("R9", "avail", 32'(avail), 32'd0);
    chk("R9", "rd_data", 32'(rd_data), 32'd0);
    #1 rst_ni = 1'b1; run_model = 1'b1;

    // scan 1, with an ignored start (R7) and reads while running
    pulse_start();
    repeat (997) @(negedge clk);
    pulse_start();
    sweep(300);
    repeat (SCAN_LEN) @(negedge clk);
    sweep(3);
    pulse_clr();
    repeat (4) @(negedge clk);

    // scan 2: clear while busy has no effect
    pulse_start();
    repeat (2000) @(negedge clk);
    pulse_clr();
    sweep(250);
    repeat (SCAN_LEN) @(negedge clk);
    sweep(3);

    // scan 3 without clearing: start clears avail (R6); old values held until rewritten (R8)
    pulse_start();
    sweep(500);
    repeat (SCAN_LEN) @(negedge clk);
    sweep(3);
    chk("R4", "channels in last scan", 32'(s_ch), 32'(NCH));

    summary();
    $finish;
  end
endmodule